// File: doc/BRIEF.md
# Sampled Position and Velocity Readout Port

This block holds a snapshot of two live 12-bit measurements, an unsigned shaft angle and a signed (two's complement) rate, and hands one of them to a host. A falling edge on the active-low sample strobe copies both live values into holding registers. A later read frame then selects one of them with a select input and presents it in one of two ways. In parallel mode the value goes out on a 12-bit bus. In serial mode it goes out as a 16-bit word that an external serial clock shifts out on a single pin.

The serial word is built when the read strobe falls. The 12 data bits come first, most significant bit first. A source tag, two fault flags and an odd-parity bit follow. The fault flags are captured together with the data, so every word is consistent with itself. All strobes and the serial clock are brought into the system clock domain through two-flop synchronizers, and all actions run from detected edges. The serial clock therefore has to stay below one quarter of the system clock rate.

Top module: `snapro_top`

## Requirements
- R1: A falling edge of `smp_n` copies `pos_in` and `vel_in` into the holding registers. Until the next such edge, changes on the live inputs have no effect on the data that is read. After reset both holding registers read as zero.
- R2: When the read strobe falls, `sel_pos` = 1 selects the position register and `sel_pos` = 0 selects the velocity register. The selected value appears unchanged as the data field.
- R3: The serial word layout is: bits 15..4 hold the selected data, bit 3 holds the select state (1 = position), bit 2 holds `flt_deg`, bit 1 holds `flt_trk` and bit 0 holds parity.
- R4: Parity is odd. Every 16-bit word holds an odd number of ones.
- R5: In serial mode, within 4 system clocks after `rd_n` falls with `cs_n` low, bit 15 is on `bus_o[11]`, with no serial clock edge needed. Within 4 system clocks after each later rising edge of `sclk_in`, the next lower bit is on `bus_o[11]`.
- R6: If `rd_n` stays low after all 16 bits have been shifted out, further rising edges of `sclk_in` put zeros on `bus_o[11]`.
- R7: In serial mode (`ser_mode_n` = 0), `bus_oe[9:0]` and `bus_oe[10]` are 0 at all times. `bus_oe[11]` is 1 only while `cs_n` and `rd_n` are both low.
- R8: In parallel mode (`ser_mode_n` = 1), `bus_oe` is all ones while `cs_n` and `rd_n` are both low, and all zeros otherwise. Within 4 system clocks after the read strobe falls, `bus_o` carries the selected 12-bit value.
- R9: The flag and select values in the word are the ones present when the read strobe falls. Changing `flt_deg` or `flt_trk` during the shift leaves the word unchanged.
- R10: A falling edge of `rd_n` while `cs_n` is high loads nothing. The previously loaded value stays on the bus when `cs_n` is lowered later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pos_in | input | 12 | Live unsigned angle value |
| vel_in | input | 12 | Live two's complement rate value |
| flt_deg | input | 1 | Signal degradation flag, sent as word bit 2 |
| flt_trk | input | 1 | Tracking loss flag, sent as word bit 1 |
| smp_n | input | 1 | Sample strobe, its falling edge captures both values |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe and frame sync |
| sel_pos | input | 1 | 1 selects position, 0 selects velocity |
| ser_mode_n | input | 1 | 0 selects serial mode, 1 selects parallel mode |
| sclk_in | input | 1 | External serial clock (bus pin 10 in serial mode) |
| bus_o | output | 12 | Data bus drive value; bit 11 is the serial output |
| bus_oe | output | 12 | Per-pin output enable, 0 means high impedance |

## Verification
Random angle, rate, select and flag values are pushed through complete serial frames. Each frame is compared with a word computed in the bench, so misplaced fields, a wrong select, or even parity show up as bit mismatches. The fault flags are inverted in the middle of some shifts, which tells a load-time snapshot apart from a live feed. Extra clock edges after bit 0 show whether zeros are filled in. Directed cases cover parallel reads with enable checks in both modes, live-input changes after a sample, the read before any sample, and a read strobe falling with chip select high.

// File: rtl/snapro_pkg.sv
package snapro_pkg;
  localparam int unsigned TAG_BITS = 4;

  typedef struct packed {
    logic sel;
    logic deg;
    logic trk;
  } tag_t;
endpackage

// File: rtl/snapro_sync.sv
module snapro_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] pipe_q, pipe_d;
  logic              last_q, last_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-2:0], async_i};
    last_d = pipe_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= {STAGES{RST_VAL}};
      last_q <= RST_VAL;
    end else begin
      pipe_q <= pipe_d;
      last_q <= last_d;
    end
  end

  assign level_o = pipe_q[STAGES-1];
  assign rise_o  = pipe_q[STAGES-1] & ~last_q;
  assign fall_o  = ~pipe_q[STAGES-1] & last_q;
endmodule

// File: rtl/snapro_hold.sv
module snapro_hold #(
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] pos_i,
  input  logic [DATA_W-1:0] vel_i,
  output logic [DATA_W-1:0] pos_q,
  output logic [DATA_W-1:0] vel_q
);
  logic [DATA_W-1:0] pos_d, vel_d;

  always_comb begin
    pos_d = pos_q;
    vel_d = vel_q;
    if (cap_en) begin
      pos_d = pos_i;
      vel_d = vel_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      vel_q <= '0;
    end else begin
      pos_q <= pos_d;
      vel_q <= vel_d;
    end
  end
endmodule

// File: rtl/snapro_frame.sv
module snapro_frame
  import snapro_pkg::*;
#(
  parameter int unsigned DATA_W  = 12,
  localparam int unsigned FRAME_W = DATA_W + TAG_BITS
) (
  input  logic [DATA_W-1:0]  pos_i,
  input  logic [DATA_W-1:0]  vel_i,
  input  tag_t               tag_i,
  output logic [FRAME_W-1:0] frame_o
);
  logic [DATA_W-1:0]  pick;
  logic [FRAME_W-2:0] body;

  always_comb begin
    pick    = tag_i.sel ? pos_i : vel_i;
    body    = {pick, tag_i.sel, tag_i.deg, tag_i.trk};
    frame_o = {body, ~(^body)};
  end
endmodule

// File: rtl/snapro_shift.sv
module snapro_shift #(
  parameter int unsigned FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_en,
  input  logic               shift_en,
  input  logic [FRAME_W-1:0] frame_i,
  output logic [FRAME_W-1:0] frame_q
);
  logic [FRAME_W-1:0] frame_d;

  always_comb begin
    frame_d = frame_q;
    if (load_en)
      frame_d = frame_i;
    else if (shift_en)
      frame_d = {frame_q[FRAME_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frame_q <= '0;
    else        frame_q <= frame_d;
  end
endmodule

// File: rtl/snapro_top.sv
module snapro_top
  import snapro_pkg::*;
#(
  parameter int unsigned DATA_W      = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] pos_in,
  input  logic [DATA_W-1:0] vel_in,
  input  logic              flt_deg,
  input  logic              flt_trk,
  input  logic              smp_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              sel_pos,
  input  logic              ser_mode_n,
  input  logic              sclk_in,
  output logic [DATA_W-1:0] bus_o,
  output logic [DATA_W-1:0] bus_oe
);
  localparam int unsigned FRAME_W = DATA_W + TAG_BITS;
  localparam int unsigned N_SYNC  = 4;
  localparam int unsigned SO_IDX  = DATA_W - 1;
  localparam logic [N_SYNC-1:0] SYNC_RST = 4'b0111;

  logic [N_SYNC-1:0] raw_in, lvl, rise, fall;
  assign raw_in = {sclk_in, cs_n, rd_n, smp_n};

  for (genvar g = 0; g < N_SYNC; g++) begin : g_sync
    snapro_sync #(.STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST[g])) u_sync (
      .clk(clk), .rst_n(rst_n), .async_i(raw_in[g]),
      .level_o(lvl[g]), .rise_o(rise[g]), .fall_o(fall[g])
    );
  end

  logic smp_fall, load_en, shift_en;
  assign smp_fall = fall[0];
  assign load_en  = fall[1] & ~lvl[2];
  assign shift_en = rise[3] & ~lvl[1] & ~lvl[2] & ~ser_mode_n;

  logic [DATA_W-1:0]  pos_q, vel_q;
  logic [FRAME_W-1:0] frame_nx, frame_q;
  tag_t               tag_now;

  assign tag_now = '{sel: sel_pos, deg: flt_deg, trk: flt_trk};

  snapro_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .cap_en(smp_fall),
    .pos_i(pos_in), .vel_i(vel_in), .pos_q(pos_q), .vel_q(vel_q)
  );

  snapro_frame #(.DATA_W(DATA_W)) u_frame (
    .pos_i(pos_q), .vel_i(vel_q), .tag_i(tag_now), .frame_o(frame_nx)
  );

  snapro_shift #(.FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .shift_en(shift_en),
    .frame_i(frame_nx), .frame_q(frame_q)
  );

  logic rd_active;
  assign rd_active = ~cs_n & ~rd_n;

  always_comb begin
    bus_o  = '0;
    bus_oe = '0;
    if (ser_mode_n) begin
      bus_o  = frame_q[FRAME_W-1:TAG_BITS];
      bus_oe = {DATA_W{rd_active}};
    end else begin
      bus_o[SO_IDX]  = frame_q[FRAME_W-1];
      bus_oe[SO_IDX] = rd_active;
    end
  end
endmodule

// File: rtl/snapro_chk.sv
module snapro_chk #(
  parameter int unsigned DATA_W  = 12,
  localparam int unsigned FRAME_W = DATA_W + 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ser_mode_n,
  input logic [DATA_W-1:0]  bus_oe,
  input logic               smp_fall,
  input logic               load_en,
  input logic               shift_en,
  input logic [DATA_W-1:0]  pos_q,
  input logic [DATA_W-1:0]  vel_q,
  input logic [FRAME_W-1:0] frame_q
);
  assert_hold_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_fall |=> ($stable(pos_q) && $stable(vel_q)));

  assert_odd_parity_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (^frame_q) == 1'b1);

  assert_shift_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !load_en) |=> frame_q[FRAME_W-1:1] == $past(frame_q[FRAME_W-2:0]));

  assert_zero_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !load_en) |=> frame_q[0] == 1'b0);

  assert_serial_hiz_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_mode_n |-> bus_oe[DATA_W-2:0] == '0);

  assert_frame_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !shift_en) |=> $stable(frame_q));
endmodule

bind snapro_top snapro_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ser_mode_n(ser_mode_n), .bus_oe(bus_oe),
  .smp_fall(smp_fall), .load_en(load_en), .shift_en(shift_en),
  .pos_q(pos_q), .vel_q(vel_q), .frame_q(frame_q)
);

// File: tb/tb_snapro_top.sv
module tb_snapro_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 12;

  logic clk = 1'b0;
  logic rst_n;
  logic [W-1:0] pos_in, vel_in;
  logic flt_deg, flt_trk, smp_n, cs_n, rd_n, sel_pos, ser_mode_n, sclk_in;
  logic [W-1:0] bus_o, bus_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  snapro_top dut (
    .clk(clk), .rst_n(rst_n), .pos_in(pos_in), .vel_in(vel_in),
    .flt_deg(flt_deg), .flt_trk(flt_trk), .smp_n(smp_n), .cs_n(cs_n),
    .rd_n(rd_n), .sel_pos(sel_pos), .ser_mode_n(ser_mode_n),
    .sclk_in(sclk_in), .bus_o(bus_o), .bus_oe(bus_oe)
  );

  function automatic logic [15:0] exp_word(input logic [W-1:0] d,
                                           input logic s, input logic dg, input logic tk);
    logic [14:0] b;
    b = {d, s, dg, tk};
    return {b, ~(^b)};
  endfunction

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_sample(input logic [W-1:0] p, input logic [W-1:0] v);
    pos_in = p; vel_in = v;
    waitc(1); smp_n = 1'b0; waitc(5); smp_n = 1'b1; waitc(4);
  endtask

  task automatic ser_read(input logic s, input bit flip, output logic [15:0] got);
    ser_mode_n = 1'b0; sel_pos = s; cs_n = 1'b0; waitc(2);
    rd_n = 1'b0; waitc(5);
    check("R7 serial enables", {20'd0, bus_oe}, 32'h800);
    if (flip) begin flt_deg = ~flt_deg; flt_trk = ~flt_trk; end
    got[15] = bus_o[W-1];
    for (int i = 14; i >= 0; i--) begin
      sclk_in = 1'b1; waitc(4); sclk_in = 1'b0; waitc(4);
      got[i] = bus_o[W-1];
    end
    for (int k = 0; k < 2; k++) begin
      sclk_in = 1'b1; waitc(4); sclk_in = 1'b0; waitc(4);
      check("R6 zero fill", {31'd0, bus_o[W-1]}, 32'd0);
    end
    rd_n = 1'b1; waitc(1);
    check("R7 serial released", {20'd0, bus_oe}, 32'd0);
    cs_n = 1'b1; waitc(4);
  endtask

  task automatic par_read(input logic s, input logic [W-1:0] exp);
    ser_mode_n = 1'b1; sel_pos = s; cs_n = 1'b0; waitc(2);
    rd_n = 1'b0; waitc(5);
    check("R8 parallel enable", {20'd0, bus_oe}, 32'hFFF);
    check("R8/R2 parallel data", {20'd0, bus_o}, {20'd0, exp});
    rd_n = 1'b1; waitc(1);
    check("R8 parallel released", {20'd0, bus_oe}, 32'd0);
    cs_n = 1'b1; waitc(4);
  endtask

  initial begin
    int unused_seed;
    logic [15:0] got;
    logic [W-1:0] p, v;
    logic s, dg, tk;
    bit flip;
    unused_seed = $urandom(32'h5A17);
    rst_n = 1'b0; pos_in = '0; vel_in = '0; flt_deg = 1'b0; flt_trk = 1'b0;
    smp_n = 1'b1; cs_n = 1'b1; rd_n = 1'b1; sel_pos = 1'b1;
    ser_mode_n = 1'b1; sclk_in = 1'b0;
    waitc(3); rst_n = 1'b1; waitc(3);

    check("R8 reset idle enables", {20'd0, bus_oe}, 32'd0);
    // R1: holding registers are zero after reset, even with live inputs set
    pos_in = 12'hABC; vel_in = 12'h123;
    par_read(1'b1, 12'h000);
    par_read(1'b0, 12'h000);

    // R1: live changes after the sample are ignored
    do_sample(12'h5A5, 12'hF00);
    pos_in = 12'h111; vel_in = 12'h222;
    par_read(1'b1, 12'h5A5);
    par_read(1'b0, 12'hF00);

    // R10: read strobe falls while chip select high, then chip select drops
    par_read(1'b1, 12'h5A5);
    sel_pos = 1'b0; ser_mode_n = 1'b1; waitc(1);
    rd_n = 1'b0; waitc(5);
    check("R10 no enable with cs high", {20'd0, bus_oe}, 32'd0);
    cs_n = 1'b0; waitc(5);
    check("R10 previous value kept", {20'd0, bus_o}, 32'h5A5);
    rd_n = 1'b1; cs_n = 1'b1; waitc(4);

    // R3/R4 directed corners: all ones and all zeros data
    do_sample(12'hFFF, 12'h000);
    flt_deg = 1'b1; flt_trk = 1'b1;
    ser_read(1'b1, 1'b0, got);
    check("R3/R4 all-ones position word", {16'd0, got}, {16'd0, exp_word(12'hFFF, 1'b1, 1'b1, 1'b1)});
    flt_deg = 1'b0; flt_trk = 1'b0;
    ser_read(1'b0, 1'b0, got);
    check("R3/R4 zero velocity word", {16'd0, got}, {16'd0, exp_word(12'h000, 1'b0, 1'b0, 1'b0)});

    // R5/R2/R9: random frames, some with flags flipped mid-shift
    for (int it = 0; it < 24; it++) begin
      p = 12'($urandom); v = 12'($urandom);
      s = 1'($urandom); dg = 1'($urandom); tk = 1'($urandom);
      flip = 1'($urandom);
      do_sample(p, v);
      flt_deg = dg; flt_trk = tk;
      ser_read(s, flip, got);
      check(flip ? "R9 flags snapshot" : "R5/R2 serial word",
            {16'd0, got}, {16'd0, exp_word(s ? p : v, s, dg, tk)});
      if (it % 4 == 0) par_read(s, s ? p : v);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule